// File: doc/BRIEF.md
# Flash Block Factory-Marker Checker

This block decides whether one erase block of a NAND flash array carries a factory bad-block marker. A start pulse brings in the block index, the pages per block, the spare-area size in bytes and a policy select. The block then asks the operation sequencer for the spare area of up to two pages, one page at a time. It inspects each returned byte as it arrives and gives one verdict: good, bad or read error.

Two policies are supported. The generic policy reads the first and second pages of the block and looks only at spare byte 0 of each. The compliant policy reads the first and the last page of the block and treats a zero byte anywhere in the spare area as a marker. A marker ends the check at once. A read failure reported by the sequencer also ends it, with an error.

The controller has four states. IDLE waits for `start` and moves to ISSUE. ISSUE drives a one-cycle `rd_cmd` and moves to STREAM. STREAM consumes spare bytes. From STREAM the block goes to DONE on a failure, on a marker, or on the last byte of the second page. It goes back to ISSUE on the last byte of the first page. DONE raises `done` for one cycle and returns to IDLE.

Top module: `bbm_marker_check`

## Requirements
- R1: The first read command carries page address `blk_idx * pages_per_blk`, truncated to PAGE_W bits, and `rd_page` stays unchanged while that page's bytes stream in.
- R2: When `policy` = 0 (generic), the second read command carries the first page address plus one.
- R3: When `policy` = 1 (compliant), the second read command carries the first page address plus `pages_per_blk` minus one.
- R4: Under the generic policy, only byte index 0 of a page's spare stream can mark the block bad (a value of 0x00). Zero bytes at any other index do not change the verdict.
- R5: Under the compliant policy, a 0x00 byte at any index from 0 to `spare_size`-1 marks the block bad.
- R6: The cycle after the clock edge that accepts a marker byte, `done` is high with `is_bad` = 1. No further bytes are consumed and no further read command is issued.
- R7: If neither page holds a marker, exactly two read commands are issued, `spare_size` bytes are consumed per page, and `done` rises with `is_bad` = 0 and `rd_err` = 0.
- R8: `rd_fail` high in STREAM ends the check with `rd_err` = 1 and `is_bad` = 0 on the following cycle. This holds even when a marker byte is presented in the same cycle.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after `start` until `done`. `is_bad` and `rd_err` hold their values after `done` until the next accepted start.
- R10: A `start` pulse while `busy` is high is ignored: the page addresses of the running check are unchanged.
- R11: After reset, `done`, `busy`, `rd_cmd`, `is_bad` and `rd_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check; sampled only in IDLE |
| policy | input | 1 | 0 = generic, 1 = compliant |
| blk_idx | input | BLK_W | Block index to check |
| pages_per_blk | input | PPB_W | Pages per erase block |
| spare_size | input | SP_W | Spare bytes per page (at least 1) |
| rd_cmd | output | 1 | One-cycle spare-area read request to the sequencer |
| rd_page | output | PAGE_W | Page address of the request |
| sp_valid | input | 1 | A spare byte is presented this cycle |
| sp_byte | input | DATA_W | Spare byte value |
| rd_fail | input | 1 | Sequencer reports a failure of the current read |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle verdict strobe |
| is_bad | output | 1 | Verdict: block carries a marker |
| rd_err | output | 1 | Verdict: check aborted by a read failure |

## Verification
The abort path and the marker path can both fire in the same STREAM cycle. This happens when the sequencer flags `rd_fail` together with a 0x00 byte that would count as a marker. The bench provokes this by raising `rd_fail` on exactly the byte it has made zero. It expects an error verdict with `is_bad` low. It also checks that the number of consumed bytes stops at that byte. A separate case puts the failure one byte after a non-marker byte to show that the plain error path works on its own.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic {
        POL_GENERIC   = 1'b0,
        POL_COMPLIANT = 1'b1
    } policy_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_STREAM = 2'd2,
        S_DONE   = 2'd3
    } state_e;

endpackage

// File: rtl/bbm_page_sel.sv
module bbm_page_sel #(
    parameter int BLK_W  = 12,
    parameter int PPB_W  = 9,
    parameter int PAGE_W = 20
) (
    input  logic              compliant,
    input  logic              second,
    input  logic [BLK_W-1:0]  blk,
    input  logic [PPB_W-1:0]  ppb,
    output logic [PAGE_W-1:0] page
);

    logic [PAGE_W-1:0] base_page;
    logic [PAGE_W-1:0] ppb_wide;
    logic [PAGE_W-1:0] step;

    always_comb begin
        ppb_wide  = PAGE_W'(ppb);
        base_page = PAGE_W'(blk) * ppb_wide;
        if (!second)
            step = '0;
        else if (compliant)
            step = ppb_wide - PAGE_W'(1);
        else
            step = PAGE_W'(1);
        page = base_page + step;
    end

endmodule

// File: rtl/bbm_byte_scan.sv
module bbm_byte_scan #(
    parameter int SP_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [SP_W-1:0]   spare_size,
    input  logic              compliant,
    output logic              marker,
    output logic              last
);

    logic [SP_W-1:0] cnt_q;
    logic            is_zero;
    logic            in_scope;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (valid)
            cnt_q <= cnt_q + SP_W'(1);
    end

    always_comb begin
        is_zero  = (data == '0);
        in_scope = compliant || (cnt_q == '0);
        marker   = is_zero && in_scope;
        last     = (cnt_q == (spare_size - SP_W'(1)));
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear) |-> (cnt_q < spare_size)); // R7

endmodule

// File: rtl/bbm_marker_check.sv
module bbm_marker_check #(
    parameter int BLK_W  = 12,
    parameter int PPB_W  = 9,
    parameter int PAGE_W = 20,
    parameter int SP_W   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              policy,
    input  logic [BLK_W-1:0]  blk_idx,
    input  logic [PPB_W-1:0]  pages_per_blk,
    input  logic [SP_W-1:0]   spare_size,
    output logic              rd_cmd,
    output logic [PAGE_W-1:0] rd_page,
    input  logic              sp_valid,
    input  logic [DATA_W-1:0] sp_byte,
    input  logic              rd_fail,
    output logic              busy,
    output logic              done,
    output logic              is_bad,
    output logic              rd_err
);
    import bbm_pkg::*;

    state_e            state_q, state_d;
    policy_e           pol_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PPB_W-1:0]  ppb_q;
    logic [SP_W-1:0]   ss_q;
    logic              second_q;
    logic              bad_q;
    logic              err_q;
    logic              marker;
    logic              last_byte;
    logic              scan_clear;
    logic              in_stream;

    bbm_page_sel #(
        .BLK_W (BLK_W),
        .PPB_W (PPB_W),
        .PAGE_W(PAGE_W)
    ) u_page_sel (
        .compliant(pol_q == POL_COMPLIANT),
        .second   (second_q),
        .blk      (blk_q),
        .ppb      (ppb_q),
        .page     (rd_page)
    );

    bbm_byte_scan #(
        .SP_W  (SP_W),
        .DATA_W(DATA_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (scan_clear),
        .valid     (sp_valid && in_stream),
        .data      (sp_byte),
        .spare_size(ss_q),
        .compliant (pol_q == POL_COMPLIANT),
        .marker    (marker),
        .last      (last_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_ISSUE;
            S_ISSUE:  state_d = S_STREAM;
            S_STREAM: begin
                if (rd_fail)
                    state_d = S_DONE;
                else if (sp_valid && marker)
                    state_d = S_DONE;
                else if (sp_valid && last_byte)
                    state_d = second_q ? S_DONE : S_ISSUE;
            end
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // operands and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q    <= POL_GENERIC;
            blk_q    <= '0;
            ppb_q    <= '0;
            ss_q     <= '0;
            second_q <= 1'b0;
            bad_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    pol_q    <= policy_e'(policy);
                    blk_q    <= blk_idx;
                    ppb_q    <= pages_per_blk;
                    ss_q     <= spare_size;
                    second_q <= 1'b0;
                    bad_q    <= 1'b0;
                    err_q    <= 1'b0;
                end
                S_STREAM: begin
                    if (rd_fail)
                        err_q <= 1'b1;
                    else if (sp_valid && marker)
                        bad_q <= 1'b1;
                    else if (sp_valid && last_byte && !second_q)
                        second_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_stream  = (state_q == S_STREAM);
        scan_clear = (state_q == S_ISSUE);
        rd_cmd     = (state_q == S_ISSUE);
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_DONE);
        is_bad     = bad_q;
        rd_err     = err_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(is_bad && rd_err)); // R8

    AST_FAIL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stream && rd_fail) |=> (done && rd_err && !is_bad)); // R8

    AST_MARK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stream && sp_valid && !rd_fail && marker) |=> (done && is_bad)); // R6

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_stream |-> $stable(rd_page)); // R1

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> !rd_cmd); // R9

endmodule

// File: tb/bbm_marker_check_test.sv
module bbm_marker_check_test;

    localparam int CLK_PERIOD = 10;
    localparam int BLK_W  = 12;
    localparam int PPB_W  = 9;
    localparam int PAGE_W = 20;
    localparam int SP_W   = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              policy = 1'b0;
    logic [BLK_W-1:0]  blk_idx = '0;
    logic [PPB_W-1:0]  pages_per_blk = '0;
    logic [SP_W-1:0]   spare_size = '0;
    logic              rd_cmd;
    logic [PAGE_W-1:0] rd_page;
    logic              sp_valid = 1'b0;
    logic [DATA_W-1:0] sp_byte = '0;
    logic              rd_fail = 1'b0;
    logic              busy, done, is_bad, rd_err;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbm_marker_check #(
        .BLK_W(BLK_W), .PPB_W(PPB_W), .PAGE_W(PAGE_W), .SP_W(SP_W), .DATA_W(DATA_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .policy(policy),
        .blk_idx(blk_idx), .pages_per_blk(pages_per_blk), .spare_size(spare_size),
        .rd_cmd(rd_cmd), .rd_page(rd_page), .sp_valid(sp_valid), .sp_byte(sp_byte),
        .rd_fail(rd_fail), .busy(busy), .done(done), .is_bad(is_bad), .rd_err(rd_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // zr/zb: read and byte index of the single zero byte (-1 none)
    // fr/fb: read and byte index where rd_fail accompanies the byte (-1 none)
    task automatic scan(input string tag, input bit pol, input int blk, input int ppb,
                        input int ss, input int zr, input int zb, input int fr,
                        input int fb, input bit gaps, input bit poke);
        int  exp_reads = 0, exp_bytes = 0;
        bit  exp_bad = 0, exp_err = 0, stop = 0;
        int  reads = 0, bytes = 0, wait_n;
        bit  finished = 0;
        longint base, exp_page;
        base = (longint'(blk) * ppb) & ((64'd1 << PAGE_W) - 1);
        for (int r = 0; r < 2 && !stop; r++) begin
            exp_reads++;
            for (int k = 0; k < ss && !stop; k++) begin
                exp_bytes++;
                if (r == fr && k == fb) begin exp_err = 1; stop = 1; end
                else if (r == zr && k == zb && (pol || k == 0)) begin exp_bad = 1; stop = 1; end
            end
        end
        $display("scenario %s", tag);
        @(negedge clk);
        start = 1; policy = pol; blk_idx = BLK_W'(blk);
        pages_per_blk = PPB_W'(ppb); spare_size = SP_W'(ss);
        @(negedge clk);
        start = 0;
        check(busy == 1, "R9", "busy after start", busy, 1);
        while (!finished) begin
            wait_n = 0;
            while (!rd_cmd && !done && wait_n < 50) begin @(negedge clk); wait_n++; end
            if (done || wait_n >= 50) begin
                finished = 1;
            end else begin
                if (reads == 0) exp_page = base;
                else if (pol)   exp_page = (base + ppb - 1) & ((64'd1 << PAGE_W) - 1);
                else            exp_page = (base + 1) & ((64'd1 << PAGE_W) - 1);
                check(rd_page == PAGE_W'(exp_page), reads == 0 ? "R1" : (pol ? "R3" : "R2"),
                      "read page", rd_page, exp_page);
                reads++;
                @(negedge clk);
                for (int k = 0; k < ss; k++) begin
                    sp_valid = 1;
                    sp_byte  = ((reads - 1) == zr && k == zb) ? 8'h00 : 8'hA5 + 8'(k);
                    rd_fail  = ((reads - 1) == fr && k == fb);
                    if (poke && k == 0) begin start = 1; blk_idx = BLK_W'(blk + 7); end
                    @(negedge clk);
                    sp_valid = 0; rd_fail = 0; start = 0;
                    bytes++;
                    if (done) begin finished = 1; break; end
                    if (rd_cmd) break;
                    if (gaps) @(negedge clk);
                end
            end
        end
        check(done == 1, "R6", "done seen", done, 1);
        check(is_bad == exp_bad, exp_bad ? (pol ? "R5" : "R4") : "R7", "is_bad", is_bad, exp_bad);
        check(rd_err == exp_err, "R8", "rd_err", rd_err, exp_err);
        check(reads == exp_reads, exp_bad ? "R6" : "R7", "read commands", reads, exp_reads);
        check(bytes == exp_bytes, exp_bad ? "R6" : "R7", "bytes consumed", bytes, exp_bytes);
        @(negedge clk);
        check(done == 0, "R9", "done pulse width", done, 0);
        check(is_bad == exp_bad && rd_err == exp_err, "R9", "verdict held", {is_bad, rd_err},
              {exp_bad, exp_err});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rd_cmd == 0 && busy == 0, "R6", "quiet after done", rd_cmd, 0);
        end
    endtask

    task automatic t_reset;
        check(done == 0 && busy == 0 && rd_cmd == 0, "R11", "control after reset",
              {done, busy, rd_cmd}, 0);
        check(is_bad == 0 && rd_err == 0, "R11", "verdict after reset", {is_bad, rd_err}, 0);
    endtask

    task automatic t_generic_good;      scan("R7 generic clean",      0, 3, 64, 16, -1, -1, -1, -1, 0, 0); endtask
    task automatic t_generic_mark2;     scan("R4 generic page2 b0",   0, 5, 32, 8, 1, 0, -1, -1, 1, 0);    endtask
    task automatic t_generic_ignore;    scan("R4 generic zero b3",    0, 9, 16, 8, 0, 3, -1, -1, 0, 0);    endtask
    task automatic t_compliant_good;    scan("R7 compliant clean",    1, 2, 64, 12, -1, -1, -1, -1, 1, 0); endtask
    task automatic t_compliant_mid;     scan("R5 compliant mid",      1, 4, 128, 16, 0, 9, -1, -1, 0, 0);  endtask
    task automatic t_compliant_tail;    scan("R5 compliant last",     1, 11, 64, 10, 1, 9, -1, -1, 0, 0);  endtask
    task automatic t_compliant_single;  scan("R3 one page per block", 1, 6, 1, 4, -1, -1, -1, -1, 0, 0);   endtask
    task automatic t_fail_plain;        scan("R8 fail alone",         0, 1, 64, 8, -1, -1, 1, 2, 0, 0);    endtask
    task automatic t_fail_collide;      scan("R8 fail with marker",   1, 7, 32, 8, 0, 4, 0, 4, 0, 0);      endtask
    task automatic t_busy_start;        scan("R10 start while busy",  1, 12, 16, 6, -1, -1, -1, -1, 0, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_generic_good();
        t_generic_mark2();
        t_generic_ignore();
        t_compliant_good();
        t_compliant_mid();
        t_compliant_tail();
        t_compliant_single();
        t_fail_plain();
        t_fail_collide();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule